// File: doc/BRIEF.md
# Byte-Port Indexed Register Slave

This block is the device end of a byte-wide host port in which an address strobe picks a register and a data strobe moves one byte to or from it. A direction line chosen by the host says whether the data strobe writes or reads. Four address registers build a 29-bit byte address into a word memory. A data-window register streams 16-bit words through that address, one byte per strobe with the low byte first, and the address advances after every whole word. A status byte combines three flag inputs with the top address bits. Three write-only control bytes are passed on to a separate controller.

Memory traffic goes through a plain internal request interface. Write data, address and a one-cycle write enable go out. Read data comes back combinationally in the same cycle as the one-cycle read enable. The address counter steps only within bits 8:1, so a long burst stays inside one 512-byte page. Memory requests are allowed only while the two enable bytes hold the unlock pair.

The strobe inputs are one-cycle, active-high pulses that are already synchronous to `clk`.

Top module: `epp_index_slave`

## Requirements
- R1: An address strobe latches busIn[2:0] as the current index. A data strobe on index 0, 1 or 2 writes or reads address bits 7:0, 15:8 or 23:16 respectively.
- R2: A write to index 3 loads address bits 28:24 from busIn[4:0]. A read of index 3 returns powerOn in bit 7, dramWritten in bit 6, cartWritten in bit 5, and address bits 28:24 in bits 4:0.
- R3: On index 4 with wrDir=1, the first data strobe holds the low byte and the second issues one memWrEn pulse. That pulse carries memWrData = {second byte, first byte} and memAddr = the current address with bit 0 forced to 0.
- R4: After each complete word on index 4, read or write, address bits 8:1 increment by one modulo 256. All other address bits keep their value, so a 256-word burst ends at its starting address.
- R5: On index 4 with wrDir=0, the first data strobe issues one memRdEn pulse and returns memRdData[7:0]. The second returns bits 15:8 of that same captured word and does not access memory.
- R6: The byte phase returns to low when an index is latched and when any of indexes 0 to 3 is written.
- R7: Indexes 5, 6 and 7 write modeOut, enable1Out and enable0Out. Reads of these indexes return 0.
- R8: The port is unlocked only while enable0Out = 0x05 and enable1Out = 0x0A. While it is locked, index 4 strobes issue no memory request, do not move the address, and read back 0.
- R9: After reset, every register, busOut and both memory enables are 0.
- R10: A read strobe's byte appears on busOut after the clock edge that samples the strobe, and it stays there until the next read strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| addrStb | input | 1 | One-cycle pulse: latch index from busIn |
| dataStb | input | 1 | One-cycle pulse: access the indexed register |
| wrDir | input | 1 | 1 = data strobe writes, 0 = reads |
| busIn | input | 8 | Byte from host |
| busOut | output | 8 | Byte to host |
| powerOn | input | 1 | Status flag, bit 7 of index 3 |
| dramWritten | input | 1 | Status flag, bit 6 of index 3 |
| cartWritten | input | 1 | Status flag, bit 5 of index 3 |
| memAddr | output | 29 | Word-aligned byte address |
| memWrData | output | 16 | Word to write |
| memWrEn | output | 1 | One-cycle write request |
| memRdEn | output | 1 | One-cycle read request |
| memRdData | input | 16 | Word read, valid with memRdEn |
| modeOut | output | 8 | Mode byte |
| enable1Out | output | 8 | Enable byte 1 |
| enable0Out | output | 8 | Enable byte 0 |

## Verification
The assertions assume that addrStb and dataStb never fire in the same cycle and that each is a single-cycle pulse. They also assume that memRdData is valid in the cycle memRdEn is high. The bench drives every strobe for exactly one clock, starting and ending on falling edges, with at least one cycle between accesses. Its memory model answers reads combinationally from memAddr, which meets the timing the read-data check relies on.

// File: rtl/epp_slave_pkg.sv
package epp_slave_pkg;

  localparam logic [2:0] IDX_ADDR0 = 3'd0;
  localparam logic [2:0] IDX_ADDR3 = 3'd3;
  localparam logic [2:0] IDX_DATA  = 3'd4;
  localparam logic [2:0] IDX_MODE  = 3'd5;
  localparam logic [2:0] IDX_EN1   = 3'd6;
  localparam logic [2:0] IDX_EN0   = 3'd7;

  // strobes from control to datapath, valid for one cycle
  typedef struct packed {
    logic [3:0] addrByteWr;
    logic       modeWr;
    logic       en1Wr;
    logic       en0Wr;
    logic       loLatch;
    logic       memWrite;
    logic       memRead;
    logic       hiRead;
    logic       advance;
    logic       regRead;
    logic [2:0] regIdx;
  } ctrlStb_t;

endpackage

// File: rtl/epp_slave_ctrl.sv
module epp_slave_ctrl
  import epp_slave_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       addrStb,
  input  logic       dataStb,
  input  logic       wrDir,
  input  logic [7:0] busIn,
  input  logic       unlocked,
  output ctrlStb_t   stb,
  output logic       phaseHigh
);

  logic [2:0] idxReg;
  logic       phaseNext;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      idxReg <= '0;
    end else if (addrStb) begin
      idxReg <= busIn[2:0];
    end
  end

  always_comb begin
    stb        = '0;
    stb.regIdx = idxReg;
    if (dataStb && !addrStb) begin
      if (wrDir) begin
        case (idxReg)
          IDX_DATA: begin
            if (unlocked) begin
              if (!phaseHigh) begin
                stb.loLatch = 1'b1;
              end else begin
                stb.memWrite = 1'b1;
                stb.advance  = 1'b1;
              end
            end
          end
          IDX_MODE: stb.modeWr = 1'b1;
          IDX_EN1:  stb.en1Wr  = 1'b1;
          IDX_EN0:  stb.en0Wr  = 1'b1;
          default:  stb.addrByteWr[idxReg[1:0]] = 1'b1;
        endcase
      end else begin
        stb.regRead = 1'b1;
        if (idxReg == IDX_DATA && unlocked) begin
          if (!phaseHigh) begin
            stb.memRead = 1'b1;
          end else begin
            stb.hiRead  = 1'b1;
            stb.advance = 1'b1;
          end
        end
      end
    end
  end

  always_comb begin
    phaseNext = phaseHigh;
    if (addrStb || (stb.addrByteWr != '0)) begin
      phaseNext = 1'b0;
    end else if (stb.loLatch || stb.memRead) begin
      phaseNext = 1'b1;
    end else if (stb.memWrite || stb.hiRead) begin
      phaseNext = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phaseHigh <= 1'b0;
    end else begin
      phaseHigh <= phaseNext;
    end
  end

  // R6
  idx_latch_phase_chk: assert property (@(posedge clk) disable iff (!rstN)
    addrStb |=> !phaseHigh);

  // R5
  rd_enters_high_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.memRead |=> phaseHigh);

endmodule

// File: rtl/epp_slave_datapath.sv
module epp_slave_datapath
  import epp_slave_pkg::*;
#(
  parameter int         ADDR_W   = 29,
  parameter int         PAGE_LSB = 1,
  parameter int         PAGE_MSB = 8,
  parameter logic [7:0] UNLOCK0  = 8'h05,
  parameter logic [7:0] UNLOCK1  = 8'h0A
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStb_t          stb,
  input  logic [7:0]        busIn,
  input  logic [15:0]       memRdData,
  input  logic              powerOn,
  input  logic              dramWritten,
  input  logic              cartWritten,
  output logic [7:0]        busOut,
  output logic [ADDR_W-1:0] memAddr,
  output logic [15:0]       memWrData,
  output logic              memWrEn,
  output logic              memRdEn,
  output logic [7:0]        modeOut,
  output logic [7:0]        enable1Out,
  output logic [7:0]        enable0Out,
  output logic              unlocked
);

  localparam int ADDR_BYTES = (ADDR_W + 7) / 8;
  localparam int FULL_W     = ADDR_BYTES * 8;
  localparam int TOP_W      = ADDR_W - 8 * (ADDR_BYTES - 1);
  localparam int STAT_W     = 8 - TOP_W;
  localparam int PAGE_W     = PAGE_MSB - PAGE_LSB + 1;

  logic [FULL_W-1:0] addrReg;
  logic [FULL_W-1:0] addrNext;
  logic [7:0]        loByte;
  logic [7:0]        holdHi;
  logic [7:0]        readByte;
  logic [STAT_W-1:0] statusBits;
  logic [PAGE_W-1:0] pageNext;

  assign statusBits = STAT_W'({powerOn, dramWritten, cartWritten});

  // next address: byte writes, then in-page word step
  always_comb begin
    addrNext = addrReg;
    for (int b = 0; b < ADDR_BYTES; b++) begin
      if (stb.addrByteWr[b]) begin
        addrNext[8*b +: 8] = busIn;
      end
    end
    if (FULL_W > ADDR_W) begin
      addrNext[FULL_W-1:ADDR_W] = '0;
    end
    pageNext = addrReg[PAGE_MSB:PAGE_LSB] + PAGE_W'(1);
    if (stb.advance) begin
      addrNext[PAGE_MSB:PAGE_LSB] = pageNext;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrReg <= '0;
    end else begin
      addrReg <= addrNext;
    end
  end

  // control bytes
  always_ff @(posedge clk) begin
    if (!rstN) begin
      modeOut    <= '0;
      enable1Out <= '0;
      enable0Out <= '0;
    end else begin
      if (stb.modeWr) modeOut    <= busIn;
      if (stb.en1Wr)  enable1Out <= busIn;
      if (stb.en0Wr)  enable0Out <= busIn;
    end
  end

  assign unlocked = (enable0Out == UNLOCK0) && (enable1Out == UNLOCK1);

  // word assembly and hold
  always_ff @(posedge clk) begin
    if (!rstN) begin
      loByte <= '0;
      holdHi <= '0;
    end else begin
      if (stb.loLatch) loByte <= busIn;
      if (stb.memRead) holdHi <= memRdData[15:8];
    end
  end

  assign memAddr   = {addrReg[ADDR_W-1:1], 1'b0};
  assign memWrData = {busIn, loByte};
  assign memWrEn   = stb.memWrite;
  assign memRdEn   = stb.memRead;

  // read mux
  always_comb begin
    readByte = '0;
    if (stb.memRead) begin
      readByte = memRdData[7:0];
    end else if (stb.hiRead) begin
      readByte = holdHi;
    end else begin
      case (stb.regIdx)
        3'd0:    readByte = addrReg[7:0];
        3'd1:    readByte = addrReg[15:8];
        3'd2:    readByte = addrReg[23:16];
        3'd3:    readByte = {statusBits, addrReg[ADDR_W-1 -: TOP_W]};
        default: readByte = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busOut <= '0;
    end else if (stb.regRead) begin
      busOut <= readByte;
    end
  end

  // R4
  page_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    memWrEn |=> (addrReg[PAGE_MSB:PAGE_LSB] == PAGE_W'($past(addrReg[PAGE_MSB:PAGE_LSB]) + 1))
             && (addrReg[ADDR_W-1:PAGE_MSB+1] == $past(addrReg[ADDR_W-1:PAGE_MSB+1])));

  // R5
  rd_low_byte_chk: assert property (@(posedge clk) disable iff (!rstN)
    memRdEn |=> busOut == $past(memRdData[7:0]));

  // R10
  bus_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !stb.regRead |=> $stable(busOut));

endmodule

// File: rtl/epp_index_slave.sv
module epp_index_slave
  import epp_slave_pkg::*;
#(
  parameter int         ADDR_W  = 29,
  parameter logic [7:0] UNLOCK0 = 8'h05,
  parameter logic [7:0] UNLOCK1 = 8'h0A
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              addrStb,
  input  logic              dataStb,
  input  logic              wrDir,
  input  logic [7:0]        busIn,
  output logic [7:0]        busOut,
  input  logic              powerOn,
  input  logic              dramWritten,
  input  logic              cartWritten,
  output logic [ADDR_W-1:0] memAddr,
  output logic [15:0]       memWrData,
  output logic              memWrEn,
  output logic              memRdEn,
  input  logic [15:0]       memRdData,
  output logic [7:0]        modeOut,
  output logic [7:0]        enable1Out,
  output logic [7:0]        enable0Out
);

  ctrlStb_t stb;
  logic     unlocked;
  logic     phaseHigh;

  epp_slave_ctrl ctrl_i (
    .clk       (clk),
    .rstN      (rstN),
    .addrStb   (addrStb),
    .dataStb   (dataStb),
    .wrDir     (wrDir),
    .busIn     (busIn),
    .unlocked  (unlocked),
    .stb       (stb),
    .phaseHigh (phaseHigh)
  );

  epp_slave_datapath #(
    .ADDR_W   (ADDR_W),
    .PAGE_LSB (1),
    .PAGE_MSB (8),
    .UNLOCK0  (UNLOCK0),
    .UNLOCK1  (UNLOCK1)
  ) dp_i (
    .clk         (clk),
    .rstN        (rstN),
    .stb         (stb),
    .busIn       (busIn),
    .memRdData   (memRdData),
    .powerOn     (powerOn),
    .dramWritten (dramWritten),
    .cartWritten (cartWritten),
    .busOut      (busOut),
    .memAddr     (memAddr),
    .memWrData   (memWrData),
    .memWrEn     (memWrEn),
    .memRdEn     (memRdEn),
    .modeOut     (modeOut),
    .enable1Out  (enable1Out),
    .enable0Out  (enable0Out),
    .unlocked    (unlocked)
  );

  // R3
  req_exclusive_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({memWrEn, memRdEn}));

  // R8
  locked_no_req_chk: assert property (@(posedge clk) disable iff (!rstN)
    (memWrEn || memRdEn) |-> (enable0Out == UNLOCK0 && enable1Out == UNLOCK1));

  // R3
  wr_after_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    memWrEn |=> !memWrEn);

endmodule

// File: tb/epp_index_slave_tb_top.sv
module epp_index_slave_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        addrStb = 1'b0;
  logic        dataStb = 1'b0;
  logic        wrDir = 1'b0;
  logic [7:0]  busIn = '0;
  logic [7:0]  busOut;
  logic        powerOn = 1'b0;
  logic        dramWritten = 1'b0;
  logic        cartWritten = 1'b0;
  logic [28:0] memAddr;
  logic [15:0] memWrData;
  logic        memWrEn;
  logic        memRdEn;
  logic [15:0] memRdData;
  logic [7:0]  modeOut;
  logic [7:0]  enable1Out;
  logic [7:0]  enable0Out;

  int checks = 0;
  int failures = 0;
  int wrCount = 0;
  int rdCount = 0;
  logic [15:0] mem [0:1023];

  always #4 clk = ~clk;

  epp_index_slave dut_i (
    .clk(clk), .rstN(rstN), .addrStb(addrStb), .dataStb(dataStb), .wrDir(wrDir),
    .busIn(busIn), .busOut(busOut), .powerOn(powerOn), .dramWritten(dramWritten),
    .cartWritten(cartWritten), .memAddr(memAddr), .memWrData(memWrData),
    .memWrEn(memWrEn), .memRdEn(memRdEn), .memRdData(memRdData),
    .modeOut(modeOut), .enable1Out(enable1Out), .enable0Out(enable0Out)
  );

  assign memRdData = mem[memAddr[10:1]];

  always @(posedge clk) begin
    if (memWrEn) begin
      mem[memAddr[10:1]] <= memWrData;
      wrCount <= wrCount + 1;
    end
    if (memRdEn) rdCount <= rdCount + 1;
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic setIdx(input logic [7:0] idx);
    @(negedge clk); addrStb = 1'b1; busIn = idx;
    @(negedge clk); addrStb = 1'b0;
  endtask

  task automatic wrByte(input logic [7:0] b);
    @(negedge clk); wrDir = 1'b1; dataStb = 1'b1; busIn = b;
    @(negedge clk); dataStb = 1'b0;
  endtask

  task automatic rdByte(output logic [7:0] b);
    @(negedge clk); wrDir = 1'b0; dataStb = 1'b1;
    @(negedge clk); dataStb = 1'b0; b = busOut;
  endtask

  task automatic wrReg(input logic [7:0] idx, input logic [7:0] b);
    setIdx(idx); wrByte(b);
  endtask

  task automatic rdReg(input logic [7:0] idx, output logic [7:0] b);
    setIdx(idx); rdByte(b);
  endtask

  task automatic setAddr(input logic [28:0] a);
    wrReg(8'd0, a[7:0]); wrReg(8'd1, a[15:8]); wrReg(8'd2, a[23:16]); wrReg(8'd3, {3'b0, a[28:24]});
  endtask

  task automatic getAddr(output logic [28:0] a);
    logic [7:0] b0, b1, b2, b3;
    rdReg(8'd0, b0); rdReg(8'd1, b1); rdReg(8'd2, b2); rdReg(8'd3, b3);
    a = {b3[4:0], b2, b1, b0};
  endtask

  initial begin
    #1500000;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [7:0]  b, lo, hi;
    logic [28:0] a;
    int w0, c0;
    for (int i = 0; i < 1024; i++) mem[i] = 16'h0;
    repeat (3) @(negedge clk);
    // R9 reset state
    check("R9 busOut", busOut, 0);
    check("R9 mem enables", {memWrEn, memRdEn}, 0);
    check("R9 control bytes", {modeOut, enable1Out, enable0Out}, 0);
    rstN = 1'b1;
    getAddr(a);
    check("R9 address", a, 0);

    // R8 locked: no memory request, no advance, reads 0
    mem[0] = 16'hBEEF;
    setIdx(8'd4); wrByte(8'h11); wrByte(8'h22);
    check("R8 locked write count", wrCount, 0);
    rdReg(8'd4, b);
    check("R8 locked read zero", b, 0);
    check("R8 locked read count", rdCount, 0);
    getAddr(a);
    check("R8 locked no advance", a, 0);
    wrReg(8'd7, 8'h05);
    setIdx(8'd4); wrByte(8'h11); wrByte(8'h22);
    check("R8 half unlock no write", wrCount, 0);

    // R7 control bytes and reads of 5..7
    wrReg(8'd6, 8'h0A);
    wrReg(8'd5, 8'h03);
    check("R7 mode", modeOut, 8'h03);
    check("R7 enables", {enable1Out, enable0Out}, 16'h0A05);
    for (int k = 5; k < 8; k++) begin
      rdReg(8'(k), b);
      check("R7 write-only read zero", b, 0);
    end

    // R1 sweep on address bytes 0..2
    for (int k = 0; k < 3; k++) begin
      for (int p = 0; p < 8; p++) begin
        logic [7:0] v;
        v = 8'((p * 37 + k * 91) ^ 8'hA5);
        wrReg(8'(k), v);
        rdReg(8'(k), b);
        check("R1 address byte readback", b, v);
      end
    end

    // R2 index 3 with all status combinations
    wrReg(8'd3, 8'hFF);
    for (int s = 0; s < 8; s++) begin
      {powerOn, dramWritten, cartWritten} = 3'(s);
      rdReg(8'd3, b);
      check("R2 status and top bits", b, {3'(s), 5'h1F});
    end
    {powerOn, dramWritten, cartWritten} = 3'b000;
    wrReg(8'd3, 8'hE6);
    rdReg(8'd3, b);
    check("R2 only five bits kept", b, 8'h06);

    // R3 R4 two words from ...56
    setAddr(29'h10123456);
    w0 = wrCount;
    setIdx(8'd4);
    wrByte(8'h5A);
    check("R3 no write after low byte", wrCount, w0);
    wrByte(8'hA5); wrByte(8'h34); wrByte(8'h12);
    check("R3 write count", wrCount, w0 + 2);
    check("R3 first word", mem[10'h056 >> 1 | 10'h200], 16'hA55A);
    check("R3 second word", mem[(10'h058 >> 1) | 10'h200], 16'h1234);
    getAddr(a);
    check("R4 address after two words", a, 29'h1012345A);

    // R4 page wrap, full 256-word write then read back
    setAddr(29'h00ABC200);
    setIdx(8'd4);
    for (int i = 0; i < 256; i++) begin
      wrByte(8'(i * 3)); wrByte(8'(i ^ 8'h5C));
    end
    getAddr(a);
    check("R4 write burst wraps to start", a, 29'h00ABC200);
    c0 = rdCount;
    setIdx(8'd4);
    for (int i = 0; i < 256; i++) begin
      rdByte(lo); rdByte(hi);
      check("R5 burst read word", {hi, lo}, {8'(i ^ 8'h5C), 8'(i * 3)});
    end
    check("R5 one read per word", rdCount, c0 + 256);
    getAddr(a);
    check("R4 read burst wraps to start", a, 29'h00ABC200);

    // R4 wrap from page end keeps bit 9 and above
    setAddr(29'h00ABC3FE);
    setIdx(8'd4); wrByte(8'h01); wrByte(8'h02);
    getAddr(a);
    check("R4 last word wraps in page", a, 29'h00ABC200);
    // R3 bit 0 forced low
    setAddr(29'h00000011);
    setIdx(8'd4); wrByte(8'h77); wrByte(8'h66);
    check("R3 odd address aligned", mem[10'h008], 16'h6677);

    // R5 held high byte
    setAddr(29'h00000040);
    mem[10'h020] = 16'hC3D4;
    setIdx(8'd4);
    rdByte(lo);
    mem[10'h020] = 16'h0000;
    rdByte(hi);
    check("R5 high from held word", {hi, lo}, 16'hC3D4);

    // R6 phase reset by index latch
    setAddr(29'h00000080);
    setIdx(8'd4); wrByte(8'hEE);
    setIdx(8'd4); wrByte(8'h21); wrByte(8'h43);
    check("R6 index latch resets phase", mem[10'h040], 16'h4321);
    // R6 phase reset by address byte write
    setIdx(8'd4); wrByte(8'hDD);
    wrReg(8'd0, 8'h90);
    setIdx(8'd4); wrByte(8'h65); wrByte(8'h87);
    check("R6 address write resets phase", mem[10'h048], 16'h8765);

    // R10 busOut holds across non-read activity
    rdReg(8'd2, b);
    wrReg(8'd5, 8'h01);
    repeat (3) @(negedge clk);
    check("R10 busOut held", busOut, b);

    // R8 relock blocks again
    wrReg(8'd7, 8'h00);
    w0 = wrCount;
    setIdx(8'd4); wrByte(8'h01); wrByte(8'h02);
    check("R8 relocked write ignored", wrCount, w0);
    rdByte(b);
    check("R8 relocked read zero", b, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule